// File: doc/BRIEF.md
# Split-Mode Dual 8-bit Timer

This block is a timer unit for a microcontroller. A small mode field selects between split operation, in which the unit acts as two independent 8-bit counters (a low byte and a high byte), and a hold state used by all other mode encodings, in which neither byte counts. The low byte can count internal clock ticks or falling edges on an external event pin. It can also be gated by an external pin under software control. The high byte always counts internal ticks and is controlled only by its own run input. Each byte raises its own overflow flag when it wraps.

A second 8-bit timer runs freely on every tick and gives a one-cycle overflow pulse, for example as a serial baud tick. In split mode the high byte takes over the second timer's overflow flag, so that flag reports only the high byte's wraps while the second timer keeps running. Outside split mode the second timer's wrap sets that flag. Software reaches the mode field, both count bytes and the flags through a byte-wide register port. An interrupt controller clears each flag with a one-cycle acknowledge pulse.

Top module: `split_dual_timer`

## Requirements
- R1: Register map on `reg_addr`: 0 is the mode field, 1 is the low byte, 2 is the high byte, 3 holds the flags. A write to address 0 stores `reg_wdata[3:0]` as {gate, ext_count, sel[1:0]}. `reg_rdata` returns the value at `reg_addr` one clock later. Reads of address 0 give zero in bits 7:4. Reads of address 3 give {6'b0, flag_hi, flag_lo}.
- R2: Split mode is sel = 2'b11. In split mode with ext_count = 0, the low byte increments by one on each tick (every clock at the default prescale of 1) while its enable is high. The enable is run0 AND (NOT gate OR synchronized gate_pin).
- R3: With gate = 1, the low byte holds while the synchronized `gate_pin` is low, even if run0 is high.
- R4: In split mode with ext_count = 1, the low byte counts each falling edge of the two-flop-synchronized `event_pin`, at most one count per two clocks, and ignores ticks.
- R5: In split mode the high byte increments on each tick while run1 is high, whatever the gate and ext_count bits say.
- R6: A byte's wrap from 8'hFF to 8'h00 sets its flag (low byte sets `flag_lo`, high byte sets `flag_hi`) on the same clock edge as the wrap.
- R7: The second timer counts every tick from reset and pulses `tmr2_ovf` for one cycle every 256 ticks. In split mode its wrap never sets `flag_hi`. In any other mode its wrap sets `flag_hi`.
- R8: When sel is not 2'b11, neither count byte changes except by a register write.
- R9: A register write to a count byte takes priority over that byte's increment in the same cycle. That increment is dropped and raises no flag.
- R10: `ack_lo` and `ack_hi` clear `flag_lo` and `flag_hi`. A write to address 3 clears `flag_lo` where bit 0 is 1 and `flag_hi` where bit 1 is 1. If a set and a clear fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| run0 | input | 1 | Run control for the low byte |
| run1 | input | 1 | Run control for the high byte in split mode |
| gate_pin | input | 1 | External gate for the low byte (asynchronous) |
| event_pin | input | 1 | External event input for the low byte (asynchronous) |
| ack_lo | input | 1 | Acknowledge pulse clearing `flag_lo` |
| ack_hi | input | 1 | Acknowledge pulse clearing `flag_hi` |
| flag_lo | output | 1 | Low byte overflow flag |
| flag_hi | output | 1 | High byte (or second timer) overflow flag |
| tmr2_ovf | output | 1 | One-cycle overflow pulse of the free-running second timer |

## Verification
The bench runs the high byte idle for longer than one period of the second timer while in split mode. A design that still routes the second timer's wrap to `flag_hi` would show that flag set. It loads a count byte during the very cycle in which the byte would wrap: a design that let the increment win would show 8'h00 and a set flag instead of the loaded value. It raises an acknowledge pulse in the cycle of a wrap, where a clear-first flag would lose the overflow. It toggles the event pin in external mode: a level-sensitive design would count far more than one per falling edge. It checks that the gate pin stalls the low byte, that the high byte ignores the gate and ext_count bits, and that non-split modes freeze both bytes.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

  localparam int CNT_W = 8;
  localparam int ADDR_W = 2;
  localparam int MODE_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MODE = 2'd0,
    ADDR_LOW  = 2'd1,
    ADDR_HIGH = 2'd2,
    ADDR_FLAG = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       gate;
    logic       ext_count;
    logic [1:0] sel;
  } mode_t;

  localparam logic [1:0] SEL_SPLIT = 2'b11;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  initial begin
    if (STAGES < 2) $error("tmr_sync needs at least two stages");
  end

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst)             pc <= '0;
    else if (pc == LAST) pc <= '0;
    else                 pc <= pc + PW'(1);
  end

  assign tick = (pc == LAST);

endmodule

// File: rtl/tmr_byte_counter.sv
module tmr_byte_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + W'(1);
  end

  // a load swallows the increment, so no wrap is reported then
  assign wrap = inc && !load && (&cnt);

  assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && !inc) |=> $stable(cnt));

endmodule

// File: rtl/split_dual_timer.sv
module split_dual_timer
  import split_timer_pkg::*;
#(
  parameter int CNT_BITS    = CNT_W,
  parameter int PRESCALE    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [CNT_BITS-1:0] reg_wdata,
  output logic [CNT_BITS-1:0] reg_rdata,
  input  logic                run0,
  input  logic                run1,
  input  logic                gate_pin,
  input  logic                event_pin,
  input  logic                ack_lo,
  input  logic                ack_hi,
  output logic                flag_lo,
  output logic                flag_hi,
  output logic                tmr2_ovf
);

  localparam int NFLAG = 2;
  localparam int PAD_MODE = CNT_BITS - MODE_W;
  localparam int PAD_FLAG = CNT_BITS - NFLAG;

  // ---------------- register decode ----------------
  logic wr_mode, wr_lo, wr_hi, wr_flag;
  assign wr_mode = reg_we && (reg_addr == ADDR_MODE);
  assign wr_lo   = reg_we && (reg_addr == ADDR_LOW);
  assign wr_hi   = reg_we && (reg_addr == ADDR_HIGH);
  assign wr_flag = reg_we && (reg_addr == ADDR_FLAG);

  mode_t mode_q;
  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (wr_mode) mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
  end

  logic split;
  assign split = (mode_q.sel == SEL_SPLIT);

  // ---------------- tick and pin conditioning ----------------
  logic tick;
  tmr_tick_gen #(.DIV(PRESCALE)) u_tick (
    .clk (clk), .rst (rst), .tick (tick)
  );

  logic gate_s, ev_s, ev_d, ev_fall;
  tmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk (clk), .rst (rst), .d (gate_pin), .q (gate_s)
  );
  tmr_sync #(.STAGES(SYNC_STAGES)) u_event_sync (
    .clk (clk), .rst (rst), .d (event_pin), .q (ev_s)
  );

  always_ff @(posedge clk) begin
    if (rst) ev_d <= 1'b0;
    else     ev_d <= ev_s;
  end
  assign ev_fall = ev_d && !ev_s;

  // ---------------- low byte ----------------
  logic                lo_en, lo_inc, lo_wrap;
  logic [CNT_BITS-1:0] lo_cnt;
  assign lo_en  = run0 && (!mode_q.gate || gate_s);
  assign lo_inc = split && lo_en && (mode_q.ext_count ? ev_fall : tick);

  tmr_byte_counter #(.W(CNT_BITS)) u_lo (
    .clk (clk), .rst (rst), .load (wr_lo), .load_val (reg_wdata),
    .inc (lo_inc), .cnt (lo_cnt), .wrap (lo_wrap)
  );

  // ---------------- high byte ----------------
  logic                hi_inc, hi_wrap;
  logic [CNT_BITS-1:0] hi_cnt;
  assign hi_inc = split && run1 && tick;

  tmr_byte_counter #(.W(CNT_BITS)) u_hi (
    .clk (clk), .rst (rst), .load (wr_hi), .load_val (reg_wdata),
    .inc (hi_inc), .cnt (hi_cnt), .wrap (hi_wrap)
  );

  // ---------------- second timer (free running) ----------------
  logic                t2_wrap;
  logic [CNT_BITS-1:0] t2_cnt;
  tmr_byte_counter #(.W(CNT_BITS)) u_t2 (
    .clk (clk), .rst (rst), .load (1'b0), .load_val ('0),
    .inc (tick), .cnt (t2_cnt), .wrap (t2_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) tmr2_ovf <= 1'b0;
    else     tmr2_ovf <= t2_wrap;
  end

  // ---------------- overflow flags ----------------
  logic [NFLAG-1:0] f_set, f_clr, f_q;
  assign f_set[0] = lo_wrap;
  assign f_set[1] = split ? hi_wrap : t2_wrap;
  assign f_clr[0] = ack_lo || (wr_flag && reg_wdata[0]);
  assign f_clr[1] = ack_hi || (wr_flag && reg_wdata[1]);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           f_q[i] <= 1'b0;
      else if (f_set[i]) f_q[i] <= 1'b1;
      else if (f_clr[i]) f_q[i] <= 1'b0;
    end

    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
      f_set[i] |=> f_q[i]);

    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (rst)
      (f_clr[i] && !f_set[i]) |=> !f_q[i]);
  end

  assign flag_lo = f_q[0];
  assign flag_hi = f_q[1];

  // ---------------- read path ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        ADDR_MODE: reg_rdata <= {{PAD_MODE{1'b0}}, mode_q};
        ADDR_LOW:  reg_rdata <= lo_cnt;
        ADDR_HIGH: reg_rdata <= hi_cnt;
        default:   reg_rdata <= {{PAD_FLAG{1'b0}}, f_q};
      endcase
    end
  end

  // ---------------- checks ----------------
  assert_split_hides_t2_R7: assert property (@(posedge clk) disable iff (rst)
    (split && !hi_wrap && !flag_hi) |=> !flag_hi);

  assert_t2_wraps_to_zero_R7: assert property (@(posedge clk) disable iff (rst)
    t2_wrap |=> (t2_cnt == '0));

  assert_nonsplit_low_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (!split && !wr_lo) |=> $stable(lo_cnt));

  assert_nonsplit_high_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (!split && !wr_hi) |=> $stable(hi_cnt));

  assert_gate_stalls_low_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q.gate && !gate_s && !wr_lo) |=> $stable(lo_cnt));

  assert_edge_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    ev_fall |=> !ev_fall);

endmodule

// File: tb/split_dual_timer_tb.sv
module split_dual_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       run0, run1, gate_pin, event_pin, ack_lo, ack_hi;
  logic       flag_lo, flag_hi, tmr2_ovf;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_dual_timer u_dut (
    .clk (clk), .rst (rst), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .run0 (run0), .run1 (run1),
    .gate_pin (gate_pin), .event_pin (event_pin), .ack_lo (ack_lo), .ack_hi (ack_hi),
    .flag_lo (flag_lo), .flag_hi (flag_hi), .tmr2_ovf (tmr2_ovf)
  );

  // vector: mode, low preload, high preload, run0, run1, gate_pin, cycles
  typedef struct packed {
    logic [3:0] mode;
    logic [7:0] lo;
    logic [7:0] hi;
    logic       r0;
    logic       r1;
    logic       gp;
    logic [9:0] cyc;
  } vec_t;

  localparam logic [32:0] VECS [NVEC] = '{
    {4'h3, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 10'd10},
    {4'h3, 8'hF8, 8'h10, 1'b1, 1'b1, 1'b0, 10'd12},
    {4'h3, 8'h20, 8'hFA, 1'b1, 1'b1, 1'b1, 10'd6},
    {4'hB, 8'h50, 8'h33, 1'b1, 1'b0, 1'b0, 10'd300},
    {4'hB, 8'h50, 8'h40, 1'b1, 1'b1, 1'b1, 10'd5},
    {4'hF, 8'h77, 8'h05, 1'b1, 1'b1, 1'b0, 10'd7},
    {4'h0, 8'h11, 8'h22, 1'b1, 1'b1, 1'b1, 10'd20},
    {4'h3, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 10'd1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v8;
    rst = 1'b1; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    run0 = 1'b0; run1 = 1'b0; gate_pin = 1'b0; event_pin = 1'b0;
    ack_lo = 1'b0; ack_hi = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // reset state
    check("R6 reset flag_lo", {7'b0, flag_lo}, 8'h00);
    check("R6 reset flag_hi", {7'b0, flag_hi}, 8'h00);
    rd(2'd1, v8); check("R1 reset low byte", v8, 8'h00);
    rd(2'd0, v8); check("R1 reset mode", v8, 8'h00);

    // R1 mode readback masks upper nibble
    wr(2'd0, 8'hA6); rd(2'd0, v8); check("R1 mode readback", v8, 8'h06);
    wr(2'd0, 8'hF7); rd(2'd0, v8); check("R1 mode readback 2", v8, 8'h07);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      vec_t v;
      logic split, en_lo, en_hi;
      logic [15:0] slo, shi;
      v = vec_t'(VECS[k]);
      split = (v.mode[1:0] == 2'b11);
      en_lo = split && v.r0 && (!v.mode[3] || v.gp) && !v.mode[2];
      en_hi = split && v.r1;
      slo = 16'(v.lo) + (en_lo ? 16'(v.cyc) : 16'd0);
      shi = 16'(v.hi) + (en_hi ? 16'(v.cyc) : 16'd0);

      gate_pin = v.gp;
      wr(2'd0, {4'h0, v.mode});
      wr(2'd3, 8'h03);
      wr(2'd1, v.lo);
      wr(2'd2, v.hi);
      run0 = v.r0; run1 = v.r1;
      repeat (int'(v.cyc)) @(posedge clk);
      @(negedge clk);
      run0 = 1'b0; run1 = 1'b0;
      check($sformatf("R6 vec%0d flag_lo", k), {7'b0, flag_lo}, {7'b0, slo >= 16'd256});
      if (split)
        check($sformatf("R7 R5 vec%0d flag_hi", k), {7'b0, flag_hi}, {7'b0, shi >= 16'd256});
      rd(2'd1, v8); check($sformatf("R2 R3 R8 vec%0d low", k), v8, slo[7:0]);
      rd(2'd2, v8); check($sformatf("R5 R8 vec%0d high", k), v8, shi[7:0]);
    end
    gate_pin = 1'b0;

    // R4 external event counting
    wr(2'd0, 8'h07); wr(2'd3, 8'h03); wr(2'd1, 8'h00);
    run0 = 1'b1;
    for (int p = 0; p < 5; p++) begin
      event_pin = 1'b1; idle(2);
      event_pin = 1'b0; idle(2);
    end
    event_pin = 1'b1; idle(6);
    idle(5);
    run0 = 1'b0;
    rd(2'd1, v8); check("R4 five falling edges", v8, 8'h05);
    event_pin = 1'b0; idle(5);
    rd(2'd1, v8); check("R4 trailing fall ignored with run0 low", v8, 8'h05);

    // R9 write beats increment at wrap
    wr(2'd0, 8'h03); wr(2'd3, 8'h03); wr(2'd1, 8'hFE);
    run0 = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h40;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; run0 = 1'b0;
    check("R9 no flag on dropped wrap", {7'b0, flag_lo}, 8'h00);
    rd(2'd1, v8); check("R9 loaded value kept", v8, 8'h40);

    // R10 set wins over acknowledge
    wr(2'd1, 8'hFF);
    run0 = 1'b1; ack_lo = 1'b1;
    @(posedge clk); @(negedge clk);
    run0 = 1'b0; ack_lo = 1'b0;
    check("R10 set beats ack", {7'b0, flag_lo}, 8'h01);
    ack_lo = 1'b1; @(posedge clk); @(negedge clk); ack_lo = 1'b0;
    check("R10 ack clears flag_lo", {7'b0, flag_lo}, 8'h00);

    // R10 software clear of flag_hi, R1 flag register read
    wr(2'd2, 8'hFF);
    run1 = 1'b1; @(posedge clk); @(negedge clk); run1 = 1'b0;
    rd(2'd3, v8); check("R1 R6 flag register shows high flag", v8, 8'h02);
    wr(2'd3, 8'h01);
    check("R10 bit0 write keeps flag_hi", {7'b0, flag_hi}, 8'h01);
    wr(2'd3, 8'h02);
    check("R10 bit1 write clears flag_hi", {7'b0, flag_hi}, 8'h00);
    ack_hi = 1'b0;

    // R7 second timer period
    begin
      int n;
      n = 0;
      while (!tmr2_ovf && n < 600) begin @(negedge clk); n++; end
      n = 0;
      do begin @(negedge clk); n++; end while (!tmr2_ovf && n < 600);
      check("R7 tmr2 period", 8'(n), 8'(256));
    end

    // R7 second timer sets flag_hi outside split mode
    wr(2'd0, 8'h00); wr(2'd3, 8'h03);
    idle(300);
    check("R7 nonsplit flag_hi from tmr2", {7'b0, flag_hi}, 8'h01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule